// File: doc/BRIEF.md
# Grouped GPIO Pin Interrupt Combiner

This block folds the levels of up to 256 GPIO pins, arranged as eight ports of 32 pins each, into grouped interrupt lines. Two independent groups are built side by side. Each group holds its own configuration: for every pin, one bit chooses the active level and one bit admits the pin into the group. A group's interrupt is raised while at least one admitted pin sits at its chosen active level. It falls once no admitted pin does, or once no pin is admitted at all.

Pins enter as a flat vector, with pin m of port p at bit p*32+m. They pass through a two-flop synchronizer before matching, and each group's interrupt leaves the block from a register. Software sets up the groups through a plain word-wide register bus. The bus has a write strobe, an address, write data and a combinational read-data return. Each group has one level-select word and one admit word per port.

Top module: `grp_irq_combiner`

## Requirements
- R1: After reset every level-select word reads 32'hFFFF_FFFF (all active high), every admit word reads 0, and both interrupt outputs are 0.
- R2: A write with wr_en high stores wdata into the addressed word at the next rising edge, and no other word changes. rdata always shows the stored value of the word that addr selects.
- R3: An admitted pin whose level-select bit is 1 drives its group's interrupt while the pin is high, and does not drive it while the pin is low.
- R4: An admitted pin whose level-select bit is 0 drives its group's interrupt while the pin is low, and does not drive it while the pin is high.
- R5: A pin whose admit bit is 0 never drives the interrupt, whatever its level. With all admit words at 0 the group interrupt stays 0 even when every pin matches its level select.
- R6: A group's interrupt is the OR of the matches of all admitted pins across all eight ports. Any single matching pin on any port raises it.
- R7: Each group uses only its own level-select and admit words. Configuring one group never changes the interrupt of the other.
- R8: A pin change driven before rising edge k shows on the interrupt after edge k+2 (three edges: two synchronizer stages and the output register). A configuration write taking effect at edge k shows on the interrupt after edge k+1.
- R9: The byte address is 7 bits. Bit 6 selects the group, and bit 5 selects the word kind (0 level select, 1 admit). Bits 4:2 give the port number, and bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 7 | Byte address of the word to read or write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Stored value of the addressed word |
| pins | input | 256 | Raw pin levels, pin m of port p at bit p*32+m |
| irq | output | 2 | Registered grouped interrupt, one bit per group |

## Verification
A single pin is tried in both level-select settings, high and low. This separates the active-high match from the active-low match, and it shows the admit bit gating an otherwise matching pin. Two pins at opposite ends of the vector (port 0 pin 0 and port 7 pin 31) are driven alone and then together. This confirms the OR reaches across ports, and that group 1's settings never move group 0. Randomized pin vectors with sparse admit masks and mixed level selects are compared with a reference sum over both groups. Edge-by-edge samples after a pin change and after a configuration write pin down the three-edge and two-edge latencies.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;

    typedef enum logic {
        CFG_LEVEL = 1'b0,
        CFG_ADMIT = 1'b1
    } cfg_kind_e;

    localparam int BYTE_OFS_W = 2;

endpackage

// File: rtl/grp_pin_sync.sv
module grp_pin_sync #(
    parameter int WIDTH = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = din;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout = st_q.stable;

    assert_sync_two_stage_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        $past(rst_n, 2) |-> dout == $past(din, 2)
    );

endmodule

// File: rtl/grp_cfg_regs.sv
module grp_cfg_regs
    import grp_irq_pkg::*;
#(
    parameter int NUM_GROUPS = 2,
    parameter int NUM_PORTS  = 8,
    parameter int PORT_W     = 32,
    parameter int ADDR_W     = 7
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         wr_en,
    input  logic [ADDR_W-1:0]                            addr,
    input  logic [PORT_W-1:0]                            wdata,
    output logic [PORT_W-1:0]                            rdata,
    output logic [NUM_GROUPS-1:0][NUM_PORTS-1:0][PORT_W-1:0] level_sel,
    output logic [NUM_GROUPS-1:0][NUM_PORTS-1:0][PORT_W-1:0] admit
);

    localparam int PIDX_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam int GIDX_W   = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
    localparam int PIDX_LSB = BYTE_OFS_W;
    localparam int KIND_BIT = BYTE_OFS_W + PIDX_W;
    localparam int GIDX_LSB = KIND_BIT + 1;

    typedef struct packed {
        logic [NUM_GROUPS-1:0][NUM_PORTS-1:0][PORT_W-1:0] lvl;
        logic [NUM_GROUPS-1:0][NUM_PORTS-1:0][PORT_W-1:0] adm;
    } cfg_t;

    cfg_t st_d, st_q;

    logic [GIDX_W-1:0] grp_idx;
    logic [PIDX_W-1:0] port_idx;
    cfg_kind_e         kind;
    logic              hit;

    always_comb begin
        grp_idx  = addr[GIDX_LSB +: GIDX_W];
        port_idx = addr[PIDX_LSB +: PIDX_W];
        kind     = cfg_kind_e'(addr[KIND_BIT]);
        hit      = (int'(grp_idx) < NUM_GROUPS) && (int'(port_idx) < NUM_PORTS);
    end

    always_comb begin
        st_d = st_q;
        if (wr_en && hit) begin
            if (kind == CFG_ADMIT) begin
                st_d.adm[grp_idx][port_idx] = wdata;
            end else begin
                st_d.lvl[grp_idx][port_idx] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lvl <= '1;
            st_q.adm <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata = (kind == CFG_ADMIT) ? st_q.adm[grp_idx][port_idx]
                                        : st_q.lvl[grp_idx][port_idx];
        end
    end

    assign level_sel = st_q.lvl;
    assign admit     = st_q.adm;

    assert_cfg_reset_R1: assert property (
        @(posedge clk)
        !rst_n |=> (st_q.lvl == '1 && st_q.adm == '0)
    );

    assert_cfg_write_admit_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        (wr_en && hit && kind == CFG_ADMIT) |=>
            st_q.adm[$past(grp_idx)][$past(port_idx)] == $past(wdata)
    );

    assert_cfg_write_level_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        (wr_en && hit && kind == CFG_LEVEL) |=>
            st_q.lvl[$past(grp_idx)][$past(port_idx)] == $past(wdata)
    );

    assert_cfg_hold_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q)
    );

endmodule

// File: rtl/grp_match.sv
module grp_match #(
    parameter int NUM_PORTS = 8,
    parameter int PORT_W    = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_PORTS-1:0][PORT_W-1:0]    pins_sync,
    input  logic [NUM_PORTS-1:0][PORT_W-1:0]    level_sel,
    input  logic [NUM_PORTS-1:0][PORT_W-1:0]    admit,
    output logic                                irq
);

    typedef struct packed {
        logic irq;
    } match_t;

    match_t st_d, st_q;

    logic [NUM_PORTS-1:0] port_hit;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [PORT_W-1:0] at_level;
        assign at_level    = ~(pins_sync[p] ^ level_sel[p]);
        assign port_hit[p] = |(at_level & admit[p]);
    end

    always_comb begin
        st_d     = st_q;
        st_d.irq = |port_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.irq;

    assert_irq_needs_admit_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (admit == '0) |=> !irq
    );

    assert_irq_reset_R1: assert property (
        @(posedge clk)
        !rst_n |=> !irq
    );

endmodule

// File: rtl/grp_irq_combiner.sv
module grp_irq_combiner
    import grp_irq_pkg::*;
#(
    parameter int NUM_GROUPS = 2,
    parameter int NUM_PORTS  = 8,
    parameter int PORT_W     = 32,
    parameter int ADDR_W     = BYTE_OFS_W + ((NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1)
                               + 1 + ((NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [PORT_W-1:0]             wdata,
    output logic [PORT_W-1:0]             rdata,
    input  logic [NUM_PORTS*PORT_W-1:0]   pins,
    output logic [NUM_GROUPS-1:0]         irq
);

    localparam int PIN_COUNT = NUM_PORTS * PORT_W;

    logic [PIN_COUNT-1:0]                              pins_flat_sync;
    logic [NUM_PORTS-1:0][PORT_W-1:0]                  pins_sync;
    logic [NUM_GROUPS-1:0][NUM_PORTS-1:0][PORT_W-1:0]  level_sel;
    logic [NUM_GROUPS-1:0][NUM_PORTS-1:0][PORT_W-1:0]  admit;

    grp_pin_sync #(
        .WIDTH (PIN_COUNT)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pins),
        .dout  (pins_flat_sync)
    );

    assign pins_sync = pins_flat_sync;

    grp_cfg_regs #(
        .NUM_GROUPS (NUM_GROUPS),
        .NUM_PORTS  (NUM_PORTS),
        .PORT_W     (PORT_W),
        .ADDR_W     (ADDR_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .level_sel (level_sel),
        .admit     (admit)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
        grp_match #(
            .NUM_PORTS (NUM_PORTS),
            .PORT_W    (PORT_W)
        ) u_match (
            .clk       (clk),
            .rst_n     (rst_n),
            .pins_sync (pins_sync),
            .level_sel (level_sel[g]),
            .admit     (admit[g]),
            .irq       (irq[g])
        );
    end

endmodule

// File: tb/grp_irq_combiner_test.sv
module grp_irq_combiner_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [6:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic [255:0] pins = '0;
    logic [1:0]   irq;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [1:0][7:0][31:0] m_lvl;
    logic [1:0][7:0][31:0] m_adm;

    typedef struct {
        int          due;
        bit          is_rd;
        logic [31:0] exp;
        string       req;
    } sb_item_t;

    sb_item_t sb[$];

    grp_irq_combiner uut (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .pins  (pins),
        .irq   (irq)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compares queued expectations when they fall due
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            sb_item_t it;
            logic [31:0] act;
            it  = sb.pop_front();
            act = it.is_rd ? rdata : {30'd0, irq};
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: %s actual=%h expected=%h", it.req,
                         it.is_rd ? "rdata" : "irq", act, it.exp);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    function automatic logic [6:0] mk_addr(int g, int kind, int p, int ofs);
        logic [6:0] a;
        a = {g[0], kind[0], p[2:0], ofs[1:0]};
        return a;
    endfunction

    function automatic logic [1:0] model_irq();
        logic [1:0] r;
        r = '0;
        for (int g = 0; g < 2; g++)
            for (int p = 0; p < 8; p++)
                r[g] = r[g] | (|(m_adm[g][p] & ~(pins[p*32 +: 32] ^ m_lvl[g][p])));
        return r;
    endfunction

    task automatic push(int due, bit is_rd, logic [31:0] exp, string req);
        sb_item_t it;
        it.due = due; it.is_rd = is_rd; it.exp = exp; it.req = req;
        sb.push_back(it);
    endtask

    task automatic wr(int g, int kind, int p, logic [31:0] d, int ofs = 0);
        tick();
        wr_en = 1'b1;
        addr  = mk_addr(g, kind, p, ofs);
        wdata = d;
        if (kind != 0) m_adm[g][p] = d; else m_lvl[g][p] = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic chk_rd(int g, int kind, int p, logic [31:0] exp, string req, int ofs = 0);
        tick();
        addr = mk_addr(g, kind, p, ofs);
        push(cyc + 1, 1'b1, exp, req);
        tick();
    endtask

    task automatic chk_model(string req);
        repeat (4) tick();
        push(cyc + 1, 1'b0, {30'd0, model_irq()}, req);
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int k;
        m_lvl = '1;
        m_adm = '0;
        pins  = '1;
        repeat (4) tick();
        rst_n = 1'b1;

        // R1: reset values; all pins match level select but nothing admitted
        chk_model("R1");
        chk_rd(0, 0, 3, 32'hFFFF_FFFF, "R1");
        chk_rd(1, 1, 7, 32'h0, "R1");
        chk_rd(1, 0, 0, 32'hFFFF_FFFF, "R1");
        chk_model("R5");

        // R2 and R9: write and read back, neighbours untouched, offset bits ignored
        wr(0, 0, 2, 32'h1234_5678);
        chk_rd(0, 0, 2, 32'h1234_5678, "R2");
        chk_rd(0, 0, 1, 32'hFFFF_FFFF, "R2");
        chk_rd(1, 0, 2, 32'hFFFF_FFFF, "R9");
        chk_rd(0, 1, 2, 32'h0, "R9");
        wr(1, 1, 5, 32'hA5A5_0F0F, 3);
        chk_rd(1, 1, 5, 32'hA5A5_0F0F, "R9", 1);
        chk_rd(0, 1, 5, 32'h0, "R7");
        wr(0, 0, 2, 32'hFFFF_FFFF);
        wr(1, 1, 5, 32'h0);

        // R3 / R8: active-high pin, exact pin-to-irq latency
        pins = '0;
        wr(0, 1, 4, 32'h0000_0200);
        chk_model("R3");
        tick();
        k = cyc;
        pins[4*32+9] = 1'b1;
        push(k + 2, 1'b0, 32'h0, "R8");
        push(k + 3, 1'b0, 32'h1, "R8");
        repeat (3) tick();
        chk_model("R3");
        pins[4*32+9] = 1'b0;
        chk_model("R3");
        pins[4*32+9] = 1'b1;
        chk_model("R7");

        // R8: configuration write latency (admit removed)
        tick();
        k = cyc;
        wr_en = 1'b1;
        addr  = mk_addr(0, 1, 4, 0);
        wdata = 32'h0;
        m_adm[0][4] = 32'h0;
        push(k + 1, 1'b0, 32'h1, "R8");
        push(k + 2, 1'b0, 32'h0, "R8");
        tick();
        wr_en = 1'b0;
        tick();
        chk_model("R5");

        // R4: active-low pin
        wr(0, 0, 4, 32'hFFFF_FDFF);
        wr(0, 1, 4, 32'h0000_0200);
        chk_model("R4");
        pins[4*32+9] = 1'b0;
        chk_model("R4");
        push(cyc + 1, 1'b0, 32'h1, "R4");
        tick();
        pins[4*32+9] = 1'b1;
        chk_model("R4");

        // R6 / R7: OR across ports in group 1, group 0 unaffected
        wr(1, 1, 0, 32'h0000_0001);
        wr(1, 1, 7, 32'h8000_0000);
        chk_model("R6");
        pins[7*32+31] = 1'b1;
        chk_model("R6");
        push(cyc + 1, 1'b0, 32'h2, "R7");
        tick();
        pins[7*32+31] = 1'b0;
        pins[0] = 1'b1;
        chk_model("R6");
        pins[7*32+31] = 1'b1;
        chk_model("R6");
        pins[7*32+31] = 1'b0;
        pins[0] = 1'b0;
        chk_model("R6");

        // R6 / R5: randomized patterns over both groups
        for (int it = 0; it < 12; it++) begin
            for (int g = 0; g < 2; g++) begin
                for (int p = 0; p < 8; p++) begin
                    logic [31:0] a;
                    logic [31:0] l;
                    a = $urandom & $urandom & $urandom;
                    l = $urandom;
                    wr(g, 1, p, a);
                    wr(g, 0, p, l);
                end
            end
            for (int p = 0; p < 8; p++) pins[p*32 +: 32] = $urandom;
            chk_model("R6");
            pins = ~pins;
            chk_model("R6");
        end

        repeat (3) tick();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule